// File: doc/BRIEF.md
# Predicated execute and writeback stage

This block is the last stage of a simple in-order datapath that supports guarded instructions. It holds a bank of general registers and a bank of one-bit predicate flags. Each cycle it takes one decoded operation and then either commits the result to a register or drops it as a no-op. Whether an operation commits is decided only at the point where the register would be written. This lets a compiler replace a short forward branch with a guarded operation, so that a control dependence becomes a data dependence.

Five operations are supported:
- load-immediate;
- an unsigned less-or-equal compare that writes a predicate flag;
- an add guarded by a predicate flag;
- a move that commits only when a third register reads zero;
- a memory load that commits only when a third register reads nonzero.

The memory is a small read-only word array whose contents are computed, not stored. For every operation, the registered result port reports whether a register write happened, whether a predicate write happened, and whether the operation was dropped.

Top module: `pred_exec_unit`

## Requirements
- R1: Synchronous active-high `rst` clears every general register and every predicate flag except flag 0, which reads 1. It also clears all output ports. A guarded add naming flag 1 right after reset is dropped.
- R2: General register 0 always reads zero. An operation that commits with destination 0 gives `wb_en`=0 and `quash`=0.
- R3: Load-immediate (`op_code` 1) writes `op_imm` to `op_rd` when flag `op_pg` is 1. Otherwise it is dropped.
- R4: Compare (`op_code` 2) is guarded by flag `op_pg`.
  - When it commits, it sets flag `op_pd` to 1 if register `op_rs2` <= register `op_rs1` as unsigned values, and to 0 otherwise.
  - The new flag value guards an operation issued in the very next cycle.
  - A compare naming flag 0 as destination leaves flag 0 at 1 and gives `pw_en`=0.
- R5: Guarded add (`op_code` 3) writes `rs1`+`rs2` (modulo 2^32) to `op_rd` only when flag `op_pg` is 1. Otherwise it is dropped.
- R6: Zero-move (`op_code` 4) copies register `op_rs1` to `op_rd` only when register `op_rs3` equals zero. Otherwise it is dropped.
- R7: Conditional load (`op_code` 5) writes the memory word at index (register `op_rs1` + `op_imm`) mod 16 to `op_rd` unless register `op_rs3` is zero, in which case it is dropped. Word k holds k in bits 31:16 and the bitwise inverse of k (16 bits) in bits 15:0.
- R8: A dropped operation asserts `quash` and changes no general register and no predicate flag.
- R9: Results appear on the output ports on the clock edge that executes the operation. The write itself is visible to an operation issued in the following cycle.
  - When `wb_en`=0, the ports `wb_rd` and `wb_data` read 0.
  - When `pw_en`=0, the ports `pw_idx` and `pw_val` read 0.
- R10: An operation with `op_valid`=0, or with `op_code` 0, 6 or 7, writes nothing and gives `quash`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation selector |
| op_rd | input | 4 | Destination general register |
| op_rs1 | input | 4 | First source / load base register |
| op_rs2 | input | 4 | Second source register |
| op_rs3 | input | 4 | Zero-test register for move and load |
| op_pd | input | 3 | Destination predicate flag for compare |
| op_pg | input | 3 | Guarding predicate flag |
| op_imm | input | 32 | Immediate value or load offset |
| wb_en | output | 1 | A general register was written |
| wb_rd | output | 4 | Index written |
| wb_data | output | 32 | Value written |
| pw_en | output | 1 | A predicate flag was written |
| pw_idx | output | 3 | Flag index written |
| pw_val | output | 1 | Flag value written |
| quash | output | 1 | Operation was dropped as a no-op |

## Verification
The bench targets the comparison edges:
- Equal operands must set the flag. A design using strict less-than would clear it.
- An all-ones operand against a small value must clear the flag. A signed compare would set it.

It also checks:
- A flag produced by one compare guarding the add issued in the very next cycle. A design that read a stale flag would commit or drop the wrong add.
- A follow-up read after every dropped operation, to show that a leaky gate, which would write despite raising `quash`, changed nothing.
- Writes aimed at register 0 and at flag 0.
- A load whose base plus offset wraps past the top of the address space. A design that reduced the address wrongly would return the wrong word.

// File: rtl/pred_exec_unit.sv
module pred_exec_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int NPRED = 8,
  parameter int MEM_WORDS = 16,
  localparam int RW = $clog2(NREG),
  localparam int PW = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [RW-1:0]   op_rd,
  input  logic [RW-1:0]   op_rs1,
  input  logic [RW-1:0]   op_rs2,
  input  logic [RW-1:0]   op_rs3,
  input  logic [PW-1:0]   op_pd,
  input  logic [PW-1:0]   op_pg,
  input  logic [XLEN-1:0] op_imm,
  output logic            wb_en,
  output logic [RW-1:0]   wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            pw_en,
  output logic [PW-1:0]   pw_idx,
  output logic            pw_val,
  output logic            quash
);
  localparam logic [2:0] C_LDI = 3'd1, C_CMP = 3'd2, C_ADD = 3'd3, C_MVZ = 3'd4, C_LDC = 3'd5;
  localparam logic [XLEN-1:0] MEMW = XLEN'(MEM_WORDS);
  localparam logic [XLEN-1:0] LOMASK = {{(XLEN/2){1'b0}}, {(XLEN/2){1'b1}}};

  logic [XLEN-1:0] rf [NREG];
  logic [NPRED-1:0] pf;

  wire [XLEN-1:0] va = rf[op_rs1];
  wire [XLEN-1:0] vb = rf[op_rs2];
  wire [XLEN-1:0] vc = rf[op_rs3];
  wire guard = pf[op_pg];
  wire cmp_res = vb <= va;

  wire is_ldi = op_code == C_LDI;
  wire is_cmp = op_code == C_CMP;
  wire is_add = op_code == C_ADD;
  wire is_mvz = op_code == C_MVZ;
  wire is_ldc = op_code == C_LDC;
  wire active = op_valid && (is_ldi || is_cmp || is_add || is_mvz || is_ldc);

  wire [XLEN-1:0] ld_idx = (va + op_imm) % MEMW;
  wire [XLEN-1:0] ld_word = (ld_idx << (XLEN/2)) | (LOMASK ^ ld_idx);

  logic commit;
  logic [XLEN-1:0] res;
  always_comb begin
    commit = 1'b0;
    res = '0;
    unique case (1'b1)
      is_ldi: begin commit = guard;    res = op_imm;  end
      is_cmp: begin commit = guard;                   end
      is_add: begin commit = guard;    res = va + vb; end
      is_mvz: begin commit = vc == '0; res = va;      end
      is_ldc: begin commit = vc != '0; res = ld_word; end
      default: ;
    endcase
    commit = commit && active;
  end

  wire gw = commit && !is_cmp && op_rd != '0;
  wire pw = commit && is_cmp && op_pd != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      pf      <= NPRED'(1);
      wb_en   <= 1'b0;
      wb_rd   <= '0;
      wb_data <= '0;
      pw_en   <= 1'b0;
      pw_idx  <= '0;
      pw_val  <= 1'b0;
      quash   <= 1'b0;
    end else begin
      if (gw) rf[op_rd] <= res;
      if (pw) pf[op_pd] <= cmp_res;
      wb_en   <= gw;
      wb_rd   <= gw ? op_rd : '0;
      wb_data <= gw ? res : '0;
      pw_en   <= pw;
      pw_idx  <= pw ? op_pd : '0;
      pw_val  <= pw && cmp_res;
      quash   <= active && !commit;
    end
  end

  assert_r0_zero_R2: assert property (@(posedge clk) disable iff (rst) rf[0] == '0);
  assert_p0_set_R4: assert property (@(posedge clk) disable iff (rst) pf[0]);
  assert_cmp_value_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid && is_cmp && guard && op_pd != '0 |=> pf[$past(op_pd)] == ($past(vb) <= $past(va)));
  assert_add_gate_R5: assert property (@(posedge clk) disable iff (rst)
    op_valid && is_add && !guard |=> quash && !wb_en);
  assert_mvz_gate_R6: assert property (@(posedge clk) disable iff (rst)
    op_valid && is_mvz && vc != '0 |=> quash && !wb_en);
  assert_ldc_gate_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid && is_ldc && vc == '0 |=> quash && !wb_en);
  assert_quash_silent_R8: assert property (@(posedge clk) disable iff (rst)
    quash |-> !wb_en && !pw_en);
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !quash && !wb_en && !pw_en);
endmodule

// File: tb/pred_exec_unit_tb.sv
module pred_exec_unit_tb;
  logic clk = 0, rst = 1, op_valid = 0;
  logic [2:0] op_code = 0;
  logic [3:0] op_rd = 0, op_rs1 = 0, op_rs2 = 0, op_rs3 = 0;
  logic [2:0] op_pd = 0, op_pg = 0;
  logic [31:0] op_imm = 0;
  logic wb_en, pw_en, pw_val, quash;
  logic [3:0] wb_rd;
  logic [31:0] wb_data;
  logic [2:0] pw_idx;

  pred_exec_unit u_dut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic en; logic [3:0] rd; logic [31:0] data;
    logic pwe; logic [2:0] pidx; logic pval; logic q;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  logic [31:0] m_r [16];
  logic [7:0] m_p;

  function automatic logic [31:0] mem_word(logic [31:0] k);
    return {k[15:0], ~k[15:0]};
  endfunction

  task automatic issue(input logic [2:0] c, input logic [3:0] rd, rs1, rs2, rs3,
                       input logic [2:0] pd, pg, input logic [31:0] imm,
                       input string tag, input logic v = 1'b1);
    exp_t e;
    logic cm, act, gop;
    logic [31:0] r;
    @(negedge clk);
    op_valid = v; op_code = c; op_rd = rd; op_rs1 = rs1; op_rs2 = rs2;
    op_rs3 = rs3; op_pd = pd; op_pg = pg; op_imm = imm;
    act = v && c >= 3'd1 && c <= 3'd5;
    gop = c != 3'd2;
    cm = 0; r = 0;
    case (c)
      3'd1: begin cm = m_p[pg]; r = imm; end
      3'd2: cm = m_p[pg];
      3'd3: begin cm = m_p[pg]; r = m_r[rs1] + m_r[rs2]; end
      3'd4: begin cm = m_r[rs3] == 0; r = m_r[rs1]; end
      3'd5: begin cm = m_r[rs3] != 0; r = mem_word((m_r[rs1] + imm) % 16); end
      default: ;
    endcase
    cm = cm && act;
    e = '0;
    e.q = act && !cm;
    if (cm && gop && rd != 0) begin
      e.en = 1; e.rd = rd; e.data = r; m_r[rd] = r;
    end
    if (cm && !gop && pd != 0) begin
      e.pwe = 1; e.pidx = pd; e.pval = m_r[rs2] <= m_r[rs1]; m_p[pd] = e.pval;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      exp_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {wb_en, wb_rd, wb_data, pw_en, pw_idx, pw_val, quash};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  logic done = 0;
  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_r[i] = 0;
    m_p = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    checks++;
    if ({wb_en, wb_rd, wb_data, pw_en, pw_idx, pw_val, quash} !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b expected=0", {wb_en, wb_data, pw_en, quash});
    end
    issue(3, 1, 0, 0, 0, 0, 1, 0, "R1 p1 clear after reset");
    issue(1, 1, 0, 0, 0, 0, 0, 5, "R3 ldi r1");
    issue(1, 2, 0, 0, 0, 0, 0, 7, "R3 ldi r2");
    issue(1, 0, 0, 0, 0, 0, 0, 99, "R2 write r0 ignored");
    issue(3, 11, 0, 1, 0, 0, 0, 0, "R2 r0 reads zero");
    issue(1, 3, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R3 ldi r3");
    issue(2, 0, 1, 2, 0, 1, 0, 0, "R4 cmp 7<=5 false");
    issue(2, 0, 2, 1, 0, 2, 0, 0, "R4 cmp 5<=7 true");
    issue(2, 0, 1, 1, 0, 3, 0, 0, "R4 cmp equal true");
    issue(2, 0, 1, 3, 0, 4, 0, 0, "R4 cmp unsigned all-ones");
    issue(2, 0, 1, 2, 0, 0, 0, 0, "R4 cmp to p0 ignored");
    issue(3, 4, 1, 2, 0, 0, 0, 0, "R4 p0 still one");
    issue(3, 4, 1, 2, 0, 0, 2, 0, "R5 add commits");
    issue(3, 4, 1, 1, 0, 0, 1, 0, "R5 add quashed");
    issue(3, 5, 4, 0, 0, 0, 0, 0, "R8 r4 unchanged");
    issue(1, 6, 0, 0, 0, 0, 4, 1, "R3 ldi quashed");
    issue(3, 7, 6, 1, 0, 0, 0, 0, "R8 r6 unchanged");
    issue(2, 0, 2, 1, 0, 3, 1, 0, "R8 cmp quashed");
    issue(3, 8, 1, 0, 0, 0, 3, 0, "R8 p3 unchanged");
    issue(4, 8, 2, 0, 0, 0, 0, 0, "R6 mvz commits");
    issue(4, 8, 1, 0, 1, 0, 0, 0, "R6 mvz quashed");
    issue(3, 9, 8, 0, 0, 0, 0, 0, "R8 r8 unchanged");
    issue(5, 10, 1, 0, 2, 0, 0, 3, "R7 ldc commits");
    issue(5, 10, 1, 0, 0, 0, 0, 4, "R7 ldc quashed");
    issue(3, 12, 10, 0, 0, 0, 0, 0, "R8 r10 unchanged");
    issue(5, 13, 3, 0, 1, 0, 0, 2, "R7 ldc wraps");
    issue(2, 0, 2, 1, 0, 5, 0, 0, "R9 set p5");
    issue(3, 14, 1, 2, 0, 0, 5, 0, "R9 next-cycle guard true");
    issue(2, 0, 1, 2, 0, 5, 0, 0, "R9 clear p5");
    issue(3, 14, 2, 2, 0, 0, 5, 0, "R9 next-cycle guard false");
    issue(0, 15, 1, 2, 0, 0, 0, 0, "R10 nop code");
    issue(7, 15, 1, 2, 0, 1, 0, 0, "R10 unused code");
    issue(3, 15, 1, 2, 0, 0, 0, 0, "R10 invalid op", 1'b0);
    issue(3, 15, 15, 0, 0, 0, 0, 0, "R10 r15 still zero");
    @(negedge clk) op_valid = 0;
    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule